// File: doc/BRIEF.md
# Converter Result Bus Formatter

This block places 14-bit converter results onto a 14-pin tri-state data bus. A result comes with a valid strobe and is taken in when the converter clock rises. It is then held for the whole converter-clock period. Two output formats are available. In normal mode all 14 bits appear at once. In demultiplexed mode each result is sent as two bytes on the upper pins, so an 8-bit host can collect it in one converter-clock period: the high byte while the clock is high and the low byte while it is low.

The converter clock is a slow signal that is sampled by the fast system clock. The block outputs pad data and a per-pin output enable. Two pins gate the bus: an active-low output enable and a port-select input. The bus is driven only when the output enable is low and the port select is low. Port select high means the pins belong to the parallel programming port.

Top module: `result_bus_formatter`

## Requirements
- R1: While reset is held, and until the first capture after reset, the held result is zero. With the bus enabled, every pin is then enabled and driven low.
- R2: A result is captured when the sampled converter clock goes from 0 to 1 and `res_valid` is 1. It appears on the pins one system-clock cycle after the system-clock edge that sees the clock high. The result is held until the next qualifying capture. A rising edge without `res_valid` leaves the held result unchanged.
- R3: With `demux_en` at 0 (configuration bit 7 clear), pin i carries held-result bit i for all 14 pins, in both converter-clock phases.
- R4: With `demux_en` at 1, while the sampled converter clock is high, pins 13..6 carry result bits 13..6 and pins 5..0 are driven low.
- R5: With `demux_en` at 1, while the sampled converter clock is low, pins 13..8 carry result bits 5..0 and pins 7..0 are driven low.
- R6: While `oe_n` is 1, no pin is enabled and pad data is 0 (high-impedance bus).
- R7: While `oe_n` is 0 and `port_par` is 1 (the inhibited combination), no pin is enabled and pad data is 0. Captures continue during this time.
- R8: Codes pass through in straight offset binary without change, including 0x0000, 0x2000 and 0x3FFF.
- R9: In demultiplexed mode, pins 13..6 of the high phase, followed by pins 13..8 of the low phase, rebuild exactly the 14-bit result captured at that period's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_clk | input | 1 | Converter clock, sampled by clk |
| res_data | input | 14 | Converter result, straight offset binary |
| res_valid | input | 1 | Result valid strobe, qualified by the converter-clock rise |
| demux_en | input | 1 | 1 = two-byte output, 0 = full-width output |
| oe_n | input | 1 | Active-low output enable |
| port_par | input | 1 | Port select, 1 = pins used by the parallel programming port |
| pad_do | output | 14 | Pad output data |
| pad_oe | output | 14 | Per-pin output enable |

## Verification
The assertions check on every cycle that the unused pins are low in each demultiplexed phase and that a qualified rising edge loads the held result. They also check that the held result does not move between rising edges, and that the bus is released whenever it is disabled or inhibited. Only the bench scenarios can show that the values are right end to end. These include the rebuilt two-byte word against the applied code, the extreme and mid-scale codes, a rising edge without a valid strobe, and a value captured while the bus was inhibited that shows up once the bus is enabled again.

// File: rtl/result_bus_formatter.sv
module result_bus_formatter #(
  parameter int W  = 14,
  parameter int HI = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnv_clk,
  input  logic [W-1:0] res_data,
  input  logic         res_valid,
  input  logic         demux_en,
  input  logic         oe_n,
  input  logic         port_par,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_oe
);
  localparam int LO = W - HI;

  logic         cclk_q;
  logic [W-1:0] hold;
  logic [W-1:0] word;
  logic         rise;
  logic         drive;

  assign rise  = cnv_clk & ~cclk_q;
  assign drive = ~oe_n & ~port_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cclk_q <= 1'b0;
      hold   <= '0;
    end else begin
      cclk_q <= cnv_clk;
      if (rise && res_valid) hold <= res_data;
    end
  end

  always_comb begin
    if (!demux_en)   word = hold;
    else if (cclk_q) word = {hold[W-1:LO], {LO{1'b0}}};
    else             word = {hold[LO-1:0], {HI{1'b0}}};
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_oe[i] = drive;
    assign pad_do[i] = drive & word[i];
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_clk && !cclk_q && res_valid) |=> hold == $past(res_data));

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnv_clk && !cclk_q) |=> $stable(hold));

  p_high_phase_low_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (demux_en && cclk_q) |-> pad_do[LO-1:0] == '0);

  p_low_phase_low_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (demux_en && !cclk_q) |-> pad_do[HI-1:0] == '0);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (pad_oe == '0 && pad_do == '0));

  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && port_par) |-> (pad_oe == '0 && pad_do == '0));
endmodule

// File: tb/result_bus_formatter_test.sv
module result_bus_formatter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_clk = 1'b0;
  logic [13:0] res_data = '0;
  logic        res_valid = 1'b0;
  logic        demux_en = 1'b0;
  logic        oe_n = 1'b0;
  logic        port_par = 1'b0;
  logic [13:0] pad_do;
  logic [13:0] pad_oe;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [13:0] exp_hold = '0;
  logic [13:0] hi_s, lo_s, oe_hi, oe_lo;

  always #2 clk = ~clk;

  result_bus_formatter uut (
    .clk(clk), .rst_n(rst_n), .cnv_clk(cnv_clk), .res_data(res_data),
    .res_valid(res_valid), .demux_en(demux_en), .oe_n(oe_n), .port_par(port_par),
    .pad_do(pad_do), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one converter-clock period: high phase then low phase, pins sampled at negedges
  task automatic period(input logic [13:0] v, input logic vld);
    @(negedge clk);
    cnv_clk = 1'b1; res_data = v; res_valid = vld;
    if (vld) exp_hold = v;
    @(negedge clk);
    hi_s = pad_do; oe_hi = pad_oe;
    res_valid = 1'b0; res_data = ~v;
    @(negedge clk);
    @(negedge clk);
    cnv_clk = 1'b0;
    @(negedge clk);
    lo_s = pad_do; oe_lo = pad_oe;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset data", pad_do, 14'h0000);
    check("R1 reset enable", pad_oe, 14'h3FFF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset data", pad_do, 14'h0000);
  endtask

  task automatic t_normal;
    demux_en = 1'b0;
    foreach (vals[k]) begin
      period(vals[k], 1'b1);
      check("R3 high phase", hi_s, vals[k]);
      check("R3 low phase", lo_s, vals[k]);
      check("R3 enables", oe_lo, 14'h3FFF);
    end
    period(14'h0000, 1'b1);
    check("R8 zero code", hi_s, 14'h0000);
    period(14'h3FFF, 1'b1);
    check("R8 full code", lo_s, 14'h3FFF);
    period(14'h2000, 1'b1);
    check("R8 midscale code", hi_s, 14'h2000);
  endtask
  logic [13:0] vals [3] = '{14'h1A5C, 14'h0F0F, 14'h3001};

  task automatic t_novalid;
    demux_en = 1'b0;
    period(14'h1234, 1'b1);
    period(14'h0555, 1'b0);
    check("R2 edge without valid high", hi_s, 14'h1234);
    check("R2 edge without valid low", lo_s, 14'h1234);
  endtask

  task automatic t_demux;
    demux_en = 1'b1;
    foreach (dvals[k]) begin
      period(dvals[k], 1'b1);
      check("R4 high byte", hi_s, {dvals[k][13:6], 6'b0});
      check("R5 low byte", lo_s, {dvals[k][5:0], 8'b0});
      check("R9 rebuilt word", {hi_s[13:6], lo_s[13:8]}, dvals[k]);
      check("R4 enables", oe_hi, 14'h3FFF);
    end
    demux_en = 1'b0;
  endtask
  logic [13:0] dvals [4] = '{14'h3FFF, 14'h0000, 14'h2AC7, 14'h003F};

  task automatic t_oe;
    oe_n = 1'b1;
    period(14'h2222, 1'b1);
    check("R6 no enable", oe_hi, 14'h0000);
    check("R6 data low", lo_s, 14'h0000);
    oe_n = 1'b0;
    @(negedge clk);
    check("R6 value after enable", pad_do, 14'h2222);
  endtask

  task automatic t_inhibit;
    port_par = 1'b1;
    period(14'h1DB6, 1'b1);
    check("R7 no enable", oe_hi, 14'h0000);
    check("R7 data low", hi_s, 14'h0000);
    port_par = 1'b0;
    @(negedge clk);
    check("R7 capture continued", pad_do, 14'h1DB6);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_novalid();
    t_demux();
    t_oe();
    t_inhibit();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule